// File: doc/BRIEF.md
# Bridge Forwarding Address Decoder

This block decides, for every transaction that opens on either side of a two-port bus bridge, whether the bridge should claim it. On the primary side a claim means the transaction is forwarded downstream. On the secondary side a claim means it is forwarded upstream. The decision depends on the bus command and address and on the configured forwarding windows: a 32-bit I/O window with 4 KB granularity, a 32-bit memory window with 1 MB granularity, and a 64-bit prefetchable memory window. It also depends on the secondary and subordinate bus numbers and on two legacy controls. One of these cuts an ISA alias hole out of the I/O window. The other snoops VGA palette writes.

For configuration accesses seen on the primary side, the block reports how the transaction continues. It is either converted to a local (type 0) access on the secondary bus, or passed on unchanged as a type 1 access. The address phase is presented with a one-cycle `req_vld` strobe. The decision is registered and appears one clock later, together with `dec_vld`.

The control is a two-state machine. **ST_IDLE** means no decision is on the outputs. **ST_RESP** means a registered decision is being presented. The transitions are:
- **ST_IDLE → ST_RESP** when `req_vld` is high.
- **ST_RESP → ST_RESP** when another `req_vld` arrives back-to-back.
- **ST_RESP → ST_IDLE** when `req_vld` is low.
- Reset forces **ST_IDLE**.

Top module: `bfd_decoder`

## Requirements
- R1: `dec_vld` is high exactly in the cycle after a cycle with `req_vld` high. While `dec_vld` is low, `dec_claim`, `dec_cfg_type0` and `dec_cfg_type1` are all 0, and all outputs are 0 after reset.
- R2: Downstream (`req_upstream`=0), an I/O command (4'h2 read, 4'h3 write) is claimed when all of the following hold:
  - address bits [63:32] are zero;
  - address[31:0] is at or above {io_base_hi, io_base_lo, 12'h000};
  - address[31:0] is at or below {io_limit_hi, io_limit_lo, 12'hFFF}.
- R3: With `isa_en`=1, an I/O address whose bits [31:16] are zero and whose bits [9:8] are not 00 is not claimed downstream, even inside the I/O window. Such an address is claimed upstream.
- R4: With `vga_snoop_en`=1, an I/O write (4'h3) to address 3C6h, 3C8h or 3C9h is claimed downstream regardless of the I/O window. Address 3C7h is not covered, and neither are I/O reads to these addresses.
- R5: Downstream, a memory command (4'h6, 4'h7, 4'hC, 4'hE, 4'hF) is claimed when address bits [63:32] are zero and address[31:20] lies within [mem_base, mem_limit], with both bounds inclusive.
- R6: Downstream, a memory command is claimed when address[63:20] lies within [{pf_base_up, pf_base}, {pf_limit_up, pf_limit}], with both bounds inclusive.
- R7: Downstream, a configuration command (4'hA, 4'hB) with address[1:0]=01 and address[23:16] equal to `sec_bus` is claimed with `dec_cfg_type0`=1 and `dec_cfg_type1`=0.
- R8: Downstream, a configuration command with address[1:0]=01 and a bus number above `sec_bus` and at or below `sub_bus` is claimed with `dec_cfg_type1`=1. Bus numbers outside [sec_bus, sub_bus] are not claimed. Configuration commands with address[1:0]≠01 are not claimed.
- R9: Upstream (`req_upstream`=1), I/O and memory commands are claimed only when the same address would not be claimed downstream by R2–R6.
- R10: Upstream configuration commands are never claimed, and both configuration flags stay 0.
- R11: Commands outside the I/O, memory and configuration sets (for example 4'h0 and 4'h1) are never claimed in either direction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_vld | input | 1 | Address phase strobe |
| req_upstream | input | 1 | 0 = primary-side request, 1 = secondary-side request |
| req_cmd | input | 4 | Bus command code |
| req_addr | input | ADDR_W | Transaction address |
| io_base_lo | input | 4 | I/O base address bits [15:12] |
| io_base_hi | input | 16 | I/O base address bits [31:16] |
| io_limit_lo | input | 4 | I/O limit address bits [15:12] |
| io_limit_hi | input | 16 | I/O limit address bits [31:16] |
| mem_base | input | 12 | Memory base address bits [31:20] |
| mem_limit | input | 12 | Memory limit address bits [31:20] |
| pf_base | input | 12 | Prefetchable base address bits [31:20] |
| pf_limit | input | 12 | Prefetchable limit address bits [31:20] |
| pf_base_up | input | ADDR_W-32 | Prefetchable base address upper bits |
| pf_limit_up | input | ADDR_W-32 | Prefetchable limit address upper bits |
| sec_bus | input | 8 | Secondary bus number |
| sub_bus | input | 8 | Subordinate bus number |
| isa_en | input | 1 | ISA alias hole enable |
| vga_snoop_en | input | 1 | VGA palette write snoop enable |
| dec_vld | output | 1 | Registered decision valid |
| dec_claim | output | 1 | Claim and forward |
| dec_cfg_type0 | output | 1 | Configuration access converts to type 0 |
| dec_cfg_type1 | output | 1 | Configuration access passes as type 1 |

## Verification
On every cycle, the assertions check the following:
- the one-cycle timing of the decision;
- that no claim or configuration flag is raised without `dec_vld`;
- that the two configuration flags are mutually exclusive and always come with a claim;
- that a secondary-side decision never carries a configuration flag.

Only the bench's directed scenarios can show whether the window arithmetic is right. That includes the inclusive edges of each window, the ISA hole cutting into the I/O window, the palette addresses, the bus-number ranges, and the inverse upstream decision.

// File: rtl/bfd_pkg.sv
package bfd_pkg;

    typedef enum logic [1:0] {
        CLS_NONE,
        CLS_IO,
        CLS_MEM,
        CLS_CFG
    } cmd_cls_e;

    typedef enum logic {
        ST_IDLE,
        ST_RESP
    } dec_state_e;

    localparam logic [3:0] CMD_IO_RD   = 4'h2;
    localparam logic [3:0] CMD_IO_WR   = 4'h3;
    localparam logic [3:0] CMD_MEM_RD  = 4'h6;
    localparam logic [3:0] CMD_MEM_WR  = 4'h7;
    localparam logic [3:0] CMD_CFG_RD  = 4'hA;
    localparam logic [3:0] CMD_CFG_WR  = 4'hB;
    localparam logic [3:0] CMD_MEM_RDM = 4'hC;
    localparam logic [3:0] CMD_MEM_RDL = 4'hE;
    localparam logic [3:0] CMD_MEM_WRI = 4'hF;

    function automatic cmd_cls_e classify(input logic [3:0] cmd);
        cmd_cls_e cls;
        case (cmd)
            CMD_IO_RD, CMD_IO_WR:                     cls = CLS_IO;
            CMD_MEM_RD, CMD_MEM_WR, CMD_MEM_RDM,
            CMD_MEM_RDL, CMD_MEM_WRI:                 cls = CLS_MEM;
            CMD_CFG_RD, CMD_CFG_WR:                   cls = CLS_CFG;
            default:                                  cls = CLS_NONE;
        endcase
        return cls;
    endfunction

endpackage

// File: rtl/bfd_io_win.sv
module bfd_io_win #(
    parameter int IO_HI_W   = 16,
    parameter int PAGE_W    = 12,
    parameter int ISA_TOP_W = 16
) (
    input  logic [31:0]          addr,
    input  logic                 upper_zero,
    input  logic                 is_write,
    input  logic [3:0]           base_lo,
    input  logic [IO_HI_W-1:0]   base_hi,
    input  logic [3:0]           limit_lo,
    input  logic [IO_HI_W-1:0]   limit_hi,
    input  logic                 isa_en,
    input  logic                 vga_en,
    output logic                 win_hit,
    output logic                 isa_hole,
    output logic                 vga_hit
);
    localparam int LO_BITS = 32 - IO_HI_W - 4;

    logic [31:0] lo_bound;
    logic [31:0] hi_bound;

    always_comb begin
        lo_bound = {base_hi, base_lo, {LO_BITS{1'b0}}};
        hi_bound = {limit_hi, limit_lo, {LO_BITS{1'b1}}};
        win_hit  = upper_zero && (addr >= lo_bound) && (addr <= hi_bound);
        // aliased ISA range: upper three quarters of every 1 KB block under 64 KB
        isa_hole = isa_en && upper_zero && (addr[31:ISA_TOP_W] == '0)
                   && (addr[9:8] != 2'b00);
        vga_hit  = vga_en && is_write && upper_zero &&
                   ((addr == 32'h0000_03C6) || (addr == 32'h0000_03C8) ||
                    (addr == 32'h0000_03C9));
    end

    logic unused_page;
    assign unused_page = (PAGE_W == LO_BITS);

endmodule

// File: rtl/bfd_mem_win.sv
module bfd_mem_win #(
    parameter int ADDR_W = 64,
    parameter bit PREF64 = 1'b1
) (
    input  logic [ADDR_W-1:20]   addr_mb,
    input  logic [11:0]          mem_base,
    input  logic [11:0]          mem_limit,
    input  logic [11:0]          pf_base,
    input  logic [11:0]          pf_limit,
    input  logic [ADDR_W-33:0]   pf_base_up,
    input  logic [ADDR_W-33:0]   pf_limit_up,
    output logic                 mem_hit,
    output logic                 pf_hit
);
    localparam int UP_W = ADDR_W - 32;

    logic upper_zero;

    always_comb begin
        upper_zero = (addr_mb[ADDR_W-1:32] == '0);
        mem_hit    = upper_zero && (addr_mb[31:20] >= mem_base) &&
                     (addr_mb[31:20] <= mem_limit);
    end

    generate
        if (PREF64) begin : g_pf64
            logic [UP_W+11:0] pf_lo;
            logic [UP_W+11:0] pf_hi;
            always_comb begin
                pf_lo  = {pf_base_up, pf_base};
                pf_hi  = {pf_limit_up, pf_limit};
                pf_hit = (addr_mb >= pf_lo) && (addr_mb <= pf_hi);
            end
        end else begin : g_pf32
            logic unused_up;
            assign unused_up = ^{pf_base_up, pf_limit_up};
            always_comb begin
                pf_hit = upper_zero && (addr_mb[31:20] >= pf_base) &&
                         (addr_mb[31:20] <= pf_limit);
            end
        end
    endgenerate

endmodule

// File: rtl/bfd_cfg_dec.sv
module bfd_cfg_dec #(
    parameter int BUS_W = 8
) (
    input  logic [1:0]           addr_type,
    input  logic [BUS_W-1:0]     addr_bus,
    input  logic [BUS_W-1:0]     sec_bus,
    input  logic [BUS_W-1:0]     sub_bus,
    output logic                 to_local,
    output logic                 to_pass
);
    logic is_t1;

    always_comb begin
        is_t1    = (addr_type == 2'b01);
        to_local = is_t1 && (addr_bus == sec_bus);
        to_pass  = is_t1 && (addr_bus > sec_bus) && (addr_bus <= sub_bus);
    end

endmodule

// File: rtl/bfd_decoder.sv
module bfd_decoder
    import bfd_pkg::*;
#(
    parameter int ADDR_W  = 64,
    parameter int BUS_W   = 8,
    parameter int IO_HI_W = 16,
    parameter bit PREF64  = 1'b1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_vld,
    input  logic                 req_upstream,
    input  logic [3:0]           req_cmd,
    input  logic [ADDR_W-1:0]    req_addr,
    input  logic [3:0]           io_base_lo,
    input  logic [IO_HI_W-1:0]   io_base_hi,
    input  logic [3:0]           io_limit_lo,
    input  logic [IO_HI_W-1:0]   io_limit_hi,
    input  logic [11:0]          mem_base,
    input  logic [11:0]          mem_limit,
    input  logic [11:0]          pf_base,
    input  logic [11:0]          pf_limit,
    input  logic [ADDR_W-33:0]   pf_base_up,
    input  logic [ADDR_W-33:0]   pf_limit_up,
    input  logic [BUS_W-1:0]     sec_bus,
    input  logic [BUS_W-1:0]     sub_bus,
    input  logic                 isa_en,
    input  logic                 vga_snoop_en,
    output logic                 dec_vld,
    output logic                 dec_claim,
    output logic                 dec_cfg_type0,
    output logic                 dec_cfg_type1
);
    localparam int BUS_LSB = 16;

    cmd_cls_e   cls;
    logic       hi_zero;
    logic       io_win, io_hole, io_vga;
    logic       mem_hit, pf_hit;
    logic       cfg_local, cfg_pass;
    logic       io_down, mem_down;
    logic       claim_d, t0_d, t1_d;
    dec_state_e state_q, state_d;
    logic       dir_q;

    bfd_io_win #(.IO_HI_W(IO_HI_W)) u_io (
        .addr       (req_addr[31:0]),
        .upper_zero (hi_zero),
        .is_write   (req_cmd == CMD_IO_WR),
        .base_lo    (io_base_lo),
        .base_hi    (io_base_hi),
        .limit_lo   (io_limit_lo),
        .limit_hi   (io_limit_hi),
        .isa_en     (isa_en),
        .vga_en     (vga_snoop_en),
        .win_hit    (io_win),
        .isa_hole   (io_hole),
        .vga_hit    (io_vga)
    );

    bfd_mem_win #(.ADDR_W(ADDR_W), .PREF64(PREF64)) u_mem (
        .addr_mb     (req_addr[ADDR_W-1:20]),
        .mem_base    (mem_base),
        .mem_limit   (mem_limit),
        .pf_base     (pf_base),
        .pf_limit    (pf_limit),
        .pf_base_up  (pf_base_up),
        .pf_limit_up (pf_limit_up),
        .mem_hit     (mem_hit),
        .pf_hit      (pf_hit)
    );

    bfd_cfg_dec #(.BUS_W(BUS_W)) u_cfg (
        .addr_type (req_addr[1:0]),
        .addr_bus  (req_addr[BUS_LSB+BUS_W-1:BUS_LSB]),
        .sec_bus   (sec_bus),
        .sub_bus   (sub_bus),
        .to_local  (cfg_local),
        .to_pass   (cfg_pass)
    );

    // combine window results into the direction-dependent decision
    always_comb begin
        cls      = classify(req_cmd);
        hi_zero  = (req_addr[ADDR_W-1:32] == '0);
        io_down  = (io_win && !io_hole) || io_vga;
        mem_down = mem_hit || pf_hit;
        claim_d  = 1'b0;
        t0_d     = 1'b0;
        t1_d     = 1'b0;
        unique case (cls)
            CLS_IO:   claim_d = req_upstream ? !io_down  : io_down;
            CLS_MEM:  claim_d = req_upstream ? !mem_down : mem_down;
            CLS_CFG: begin
                if (!req_upstream) begin
                    t0_d    = cfg_local;
                    t1_d    = cfg_pass;
                    claim_d = cfg_local || cfg_pass;
                end
            end
            default:  claim_d = 1'b0;
        endcase
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (req_vld)  state_d = ST_RESP;
            ST_RESP: if (!req_vld) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // registered outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dec_claim     <= 1'b0;
            dec_cfg_type0 <= 1'b0;
            dec_cfg_type1 <= 1'b0;
            dir_q         <= 1'b0;
        end else if (state_d == ST_RESP) begin
            dec_claim     <= claim_d;
            dec_cfg_type0 <= t0_d;
            dec_cfg_type1 <= t1_d;
            dir_q         <= req_upstream;
        end else begin
            dec_claim     <= 1'b0;
            dec_cfg_type0 <= 1'b0;
            dec_cfg_type1 <= 1'b0;
            dir_q         <= 1'b0;
        end
    end

    assign dec_vld = (state_q == ST_RESP);

    // R1: decision appears exactly one cycle after the strobe
    a_r1_vld_follows: assert property (@(posedge clk) disable iff (!rst_n)
        req_vld |=> dec_vld);
    a_r1_vld_drops: assert property (@(posedge clk) disable iff (!rst_n)
        !req_vld |=> !dec_vld);
    // R1: no flag without a valid decision
    a_r1_quiet_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !dec_vld |-> !(dec_claim || dec_cfg_type0 || dec_cfg_type1));
    // R7 / R8: conversion and pass-through are exclusive
    a_r8_flags_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({dec_cfg_type0, dec_cfg_type1}));
    // R7: a configuration flag always comes with a claim
    a_r7_flag_claims: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_cfg_type0 || dec_cfg_type1) |-> dec_claim);
    // R10: upstream decisions never carry configuration flags
    a_r10_up_no_cfg: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_vld && dir_q) |-> !(dec_cfg_type0 || dec_cfg_type1));

endmodule

// File: tb/bfd_decoder_tb.sv
module bfd_decoder_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_vld = 1'b0;
    logic        req_upstream = 1'b0;
    logic [3:0]  req_cmd = 4'h0;
    logic [63:0] req_addr = '0;
    logic [3:0]  io_base_lo = 4'h2, io_limit_lo = 4'h3;
    logic [15:0] io_base_hi = 16'h0, io_limit_hi = 16'h0;
    logic [11:0] mem_base = 12'h100, mem_limit = 12'h1FF;
    logic [11:0] pf_base = 12'h800, pf_limit = 12'h8FF;
    logic [31:0] pf_base_up = 32'h1, pf_limit_up = 32'h1;
    logic [7:0]  sec_bus = 8'd5, sub_bus = 8'd9;
    logic        isa_en = 1'b0, vga_snoop_en = 1'b0;
    logic        dec_vld, dec_claim, dec_cfg_type0, dec_cfg_type1;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    bfd_decoder u_dut (
        .clk(clk), .rst_n(rst_n), .req_vld(req_vld), .req_upstream(req_upstream),
        .req_cmd(req_cmd), .req_addr(req_addr),
        .io_base_lo(io_base_lo), .io_base_hi(io_base_hi),
        .io_limit_lo(io_limit_lo), .io_limit_hi(io_limit_hi),
        .mem_base(mem_base), .mem_limit(mem_limit),
        .pf_base(pf_base), .pf_limit(pf_limit),
        .pf_base_up(pf_base_up), .pf_limit_up(pf_limit_up),
        .sec_bus(sec_bus), .sub_bus(sub_bus),
        .isa_en(isa_en), .vga_snoop_en(vga_snoop_en),
        .dec_vld(dec_vld), .dec_claim(dec_claim),
        .dec_cfg_type0(dec_cfg_type0), .dec_cfg_type1(dec_cfg_type1)
    );

    task automatic expect4(input string tag, input logic v, input logic c,
                           input logic t0, input logic t1);
        n_cmp++;
        if ({dec_vld, dec_claim, dec_cfg_type0, dec_cfg_type1} !== {v, c, t0, t1}) begin
            n_bad++;
            $display("FAIL %s: got vld/claim/t0/t1=%b%b%b%b expected %b%b%b%b", tag,
                     dec_vld, dec_claim, dec_cfg_type0, dec_cfg_type1, v, c, t0, t1);
        end
    endtask

    // drive one address phase, sample the registered decision one clock later
    task automatic issue(input logic up, input logic [3:0] cmd, input logic [63:0] a);
        @(negedge clk);
        req_vld = 1'b1; req_upstream = up; req_cmd = cmd; req_addr = a;
        @(negedge clk);
        req_vld = 1'b0;
    endtask

    task automatic probe(input string tag, input logic up, input logic [3:0] cmd,
                         input logic [63:0] a, input logic c);
        issue(up, cmd, a);
        expect4(tag, 1'b1, c, 1'b0, 1'b0);
    endtask

    task automatic t_reset();
        expect4("R1 reset state", 1'b0, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic t_timing();
        issue(1'b0, 4'h2, 64'h2000);
        expect4("R1 decision one cycle later", 1'b1, 1'b1, 1'b0, 1'b0);
        @(negedge clk);
        expect4("R1 decision drops when idle", 1'b0, 1'b0, 1'b0, 1'b0);
        @(negedge clk);
        req_vld = 1'b1; req_upstream = 1'b0; req_cmd = 4'h6; req_addr = 64'h1000_0000;
        @(negedge clk);
        req_cmd = 4'h6; req_addr = 64'h3000_0000;
        expect4("R1 back-to-back first", 1'b1, 1'b1, 1'b0, 1'b0);
        @(negedge clk);
        req_vld = 1'b0;
        expect4("R1 back-to-back second", 1'b1, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic t_io_window();
        probe("R2 io base edge",        1'b0, 4'h2, 64'h2000, 1'b1);
        probe("R2 io limit edge",       1'b0, 4'h3, 64'h3FFF, 1'b1);
        probe("R2 io above limit",      1'b0, 4'h2, 64'h4000, 1'b0);
        probe("R2 io below base",       1'b0, 4'h2, 64'h1FFF, 1'b0);
        probe("R2 io upper bits set",   1'b0, 4'h2, 64'h1_0000_2000, 1'b0);
    endtask

    task automatic t_isa();
        isa_en = 1'b1;
        probe("R3 isa hole blocks",     1'b0, 4'h2, 64'h2100, 1'b0);
        probe("R3 isa low quarter ok",  1'b0, 4'h2, 64'h2400, 1'b1);
        probe("R3 isa hole upstream",   1'b1, 4'h2, 64'h2100, 1'b1);
        isa_en = 1'b0;
        probe("R3 hole off",            1'b0, 4'h2, 64'h2100, 1'b1);
    endtask

    task automatic t_vga();
        vga_snoop_en = 1'b1;
        probe("R4 palette 3C6 write",   1'b0, 4'h3, 64'h3C6, 1'b1);
        probe("R4 palette 3C9 write",   1'b0, 4'h3, 64'h3C9, 1'b1);
        probe("R4 3C7 not snooped",     1'b0, 4'h3, 64'h3C7, 1'b0);
        probe("R4 palette read",        1'b0, 4'h2, 64'h3C8, 1'b0);
        vga_snoop_en = 1'b0;
        probe("R4 snoop off",           1'b0, 4'h3, 64'h3C8, 1'b0);
    endtask

    task automatic t_mem();
        probe("R5 mem base edge",       1'b0, 4'h6, 64'h1000_0000, 1'b1);
        probe("R5 mem limit edge",      1'b0, 4'h7, 64'h1FFF_FFFC, 1'b1);
        probe("R5 mem above",           1'b0, 4'h6, 64'h2000_0000, 1'b0);
        probe("R5 mem below",           1'b0, 4'hC, 64'h0FFF_FFFC, 1'b0);
        probe("R5 mem cmd E",           1'b0, 4'hE, 64'h1800_0000, 1'b1);
    endtask

    task automatic t_pref();
        probe("R6 pf base edge",        1'b0, 4'h6, 64'h1_8000_0000, 1'b1);
        probe("R6 pf limit edge",       1'b0, 4'hF, 64'h1_8FFF_FFF0, 1'b1);
        probe("R6 pf above",            1'b0, 4'h6, 64'h1_9000_0000, 1'b0);
        probe("R6 pf low 4GB alias",    1'b0, 4'h6, 64'h0_8000_0000, 1'b0);
    endtask

    task automatic t_cfg();
        issue(1'b0, 4'hA, 64'h0005_0001);
        expect4("R7 type0 conversion", 1'b1, 1'b1, 1'b1, 1'b0);
        issue(1'b0, 4'hB, 64'h0009_0001);
        expect4("R8 type1 pass at sub", 1'b1, 1'b1, 1'b0, 1'b1);
        probe("R8 bus above sub",       1'b0, 4'hA, 64'h000A_0001, 1'b0);
        probe("R8 bus below sec",       1'b0, 4'hA, 64'h0004_0001, 1'b0);
        probe("R8 not type1 format",    1'b0, 4'hA, 64'h0006_0000, 1'b0);
    endtask

    task automatic t_upstream();
        probe("R9 up mem outside",      1'b1, 4'h6, 64'h3000_0000, 1'b1);
        probe("R9 up mem inside",       1'b1, 4'h6, 64'h1000_0000, 1'b0);
        probe("R9 up pf inside",        1'b1, 4'h7, 64'h1_8000_0000, 1'b0);
        probe("R9 up io outside",       1'b1, 4'h2, 64'h5000, 1'b1);
        probe("R9 up io inside",        1'b1, 4'h2, 64'h2000, 1'b0);
        issue(1'b1, 4'hA, 64'h0005_0001);
        expect4("R10 up cfg ignored", 1'b1, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic t_other();
        probe("R11 cmd 0 down",         1'b0, 4'h0, 64'h2000, 1'b0);
        probe("R11 cmd 1 up",           1'b1, 4'h1, 64'h5000, 1'b0);
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_timing();
        t_io_window();
        t_isa();
        t_vga();
        t_mem();
        t_pref();
        t_cfg();
        t_upstream();
        t_other();
        finished = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: got hung run expected completion");
            summary();
            $finish;
        end
    end

endmodule